// File: doc/BRIEF.md
# Undefined-Length Burst End Predictor

This block sits beside one bus master's port on a multi-layer interconnect and tells the arbiter where a burst should be treated as finished. Without it, an incrementing burst of undefined length (HBURST = INCR) could hold a slave until the master stops on its own.

A 3-bit limit setting chooses one of two policies. The first is unlimited, where only the natural 1 KB address boundary ends the burst. The second is a fixed power-of-two beat count, where the block cuts the stream into arbitration units of that size. At each such point the block raises `predEnd` for the accepted beat that closes the unit, so the arbiter may re-arbitrate after that beat.

Bursts of defined length are never split. For these the block only flags their final beat on `lastBeat`. Both outputs are combinational, valid during the clock cycle of the accepted beat they refer to. The beat count they depend on is a register that updates on the following edge.

Top module: `burstEndPredictor`

## Requirements
- R1: After reset the beat count is empty. With no NONSEQ beat, a stream of accepted SEQ beats under a limit of 8 raises `predEnd` first on the 8th of them, and both outputs stay low on IDLE cycles.
- R2: A beat is accepted only when `hready` is 1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). A cycle with `hready` at 0 neither advances the count nor raises either output.
- R3: For INCR (`hburst` = 3'b001) with `cfgLimit` from 1 to 7, the limit is 1, 4, 8, 16, 32, 64 or 128 beats respectively. `predEnd` is raised on every accepted beat whose position in the burst is a multiple of the limit, and the count restarts after it.
- R4: A NONSEQ beat always counts as beat 1 of a new burst, whatever count the previous burst left.
- R5: A BUSY cycle (`htrans` = 2'b01) does not advance the count.
- R6: An IDLE cycle (`htrans` = 2'b00) clears the count, so the next accepted beat counts as beat 1 even if it is a SEQ.
- R7: With `cfgLimit` = 0 (unlimited), `predEnd` is raised for an INCR beat only when that beat ends a 1 KB block. This is true when `haddrOfs` + 2^`hsize` ≥ 1024.
- R8: For defined-length bursts, `lastBeat` is raised on the final beat and `predEnd` is never raised, for any `cfgLimit`. The burst codes are SINGLE = 0, WRAP4 = 2, INCR4 = 3, WRAP8 = 4, INCR8 = 5, WRAP16 = 6 and INCR16 = 7, giving lengths of 1, 4, 4, 8, 8, 16 and 16 beats.
- R9: `lastBeat` is never raised during an INCR burst.
- R10: Both outputs refer to the beat accepted in the same cycle, with no register between the inputs and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hburst | input | 3 | Burst type code |
| hready | input | 1 | Transfer completes this cycle |
| hsize | input | 3 | Beat size, 2^hsize bytes |
| haddrOfs | input | BOUND_LOG | Address bits below the 1 KB boundary |
| cfgLimit | input | 3 | Split setting: 0 unlimited, 1..7 fixed beat limit |
| predEnd | output | 1 | Predicted end of an INCR arbitration unit on this beat |
| lastBeat | output | 1 | Final beat of a defined-length burst on this beat |

## Verification
The assertions assume that `hburst` and `cfgLimit` stay constant within a burst, and that `hsize` never describes a beat wider than the 1 KB window. Under these assumptions the beat position inside a limited INCR burst can never pass the selected limit.

The stimulus holds `hburst`, `hsize` and `cfgLimit` fixed from each NONSEQ until the following IDLE or NONSEQ. It steps the address by exactly one beat width per accepted beat. Wait states and BUSY cycles are inserted at fixed beat positions.

One deliberate exception is a SEQ directly after IDLE. It is included only to expose the clearing behaviour of IDLE.

// File: rtl/burstEndPkg.sv
package burstEndPkg;
  localparam int CFG_W   = 3;
  localparam int MAX_LOG = 7;
  localparam int CNT_W   = MAX_LOG + 1;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BU_INCR = 3'b001;

  typedef struct packed {
    logic             take;       // beat accepted this cycle
    logic             first;      // beat opens a new burst
    logic             wipe;       // idle cycle clears the count
    logic             incr;       // undefined-length burst
    logic             unlimited;  // no beat limit selected
    logic [CNT_W-1:0] target;     // beat limit or defined length
  } ctlStrobe_t;
endpackage

// File: rtl/burstEndCtl.sv
module burstEndCtl
  import burstEndPkg::*;
(
  input  logic [1:0]       htrans,
  input  logic [2:0]       hburst,
  input  logic             hready,
  input  logic [CFG_W-1:0] cfgLimit,
  output ctlStrobe_t       ctl
);
  logic [CNT_W-1:0] incrLimit;
  logic [CNT_W-1:0] fixedLen;

  always_comb begin
    incrLimit = (cfgLimit == CFG_W'(1)) ? CNT_W'(1) : (CNT_W'(1) << cfgLimit);
    fixedLen  = (hburst == 3'b000) ? CNT_W'(1)
                                   : (CNT_W'(1) << ({1'b0, hburst[2:1]} + 3'd1));
  end

  always_comb begin
    ctl.take      = hready && (htrans == TR_NONSEQ || htrans == TR_SEQ);
    ctl.first     = (htrans == TR_NONSEQ);
    ctl.wipe      = (htrans == TR_IDLE);
    ctl.incr      = (hburst == BU_INCR);
    ctl.unlimited = (cfgLimit == '0);
    ctl.target    = ctl.incr ? incrLimit : fixedLen;
  end
endmodule

// File: rtl/burstEndDp.sv
module burstEndDp
  import burstEndPkg::*;
#(
  parameter int BOUND_LOG = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctlStrobe_t           ctl,
  input  logic [BOUND_LOG-1:0] haddrOfs,
  input  logic [2:0]           hsize,
  output logic                 predEnd,
  output logic                 lastBeat
);
  localparam int SPAN_W = BOUND_LOG + 1;

  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  beatIdx;
  logic [SPAN_W-1:0] byteSpan;
  logic [SPAN_W-1:0] endOfs;
  logic              crossing;
  logic              hit;

  always_comb begin
    byteSpan = SPAN_W'(1) << hsize;
    endOfs   = {1'b0, haddrOfs} + byteSpan;
    crossing = endOfs[BOUND_LOG];
    beatIdx  = ctl.first ? CNT_W'(1) : count + CNT_W'(1);
    hit      = (beatIdx == ctl.target);
    predEnd  = ctl.take && ctl.incr && (ctl.unlimited ? crossing : hit);
    lastBeat = ctl.take && !ctl.incr && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (ctl.wipe)      count <= '0;
    else if (ctl.take)      count <= (predEnd || lastBeat) ? '0 : beatIdx;
  end

  // R5
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.take && !ctl.wipe) |=> $stable(count));

  // R6
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wipe |=> (count == '0));

  // R4
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.take && ctl.first) |=> (count <= CNT_W'(1)));

  // R3
  limit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.take && ctl.incr && !ctl.unlimited) |-> (beatIdx <= ctl.target));
endmodule

// File: rtl/burstEndPredictor.sv
module burstEndPredictor
  import burstEndPkg::*;
#(
  parameter int BOUND_LOG = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           htrans,
  input  logic [2:0]           hburst,
  input  logic                 hready,
  input  logic [2:0]           hsize,
  input  logic [BOUND_LOG-1:0] haddrOfs,
  input  logic [CFG_W-1:0]     cfgLimit,
  output logic                 predEnd,
  output logic                 lastBeat
);
  ctlStrobe_t ctl;

  burstEndCtl uCtl (
    .htrans   (htrans),
    .hburst   (hburst),
    .hready   (hready),
    .cfgLimit (cfgLimit),
    .ctl      (ctl)
  );

  burstEndDp #(.BOUND_LOG(BOUND_LOG)) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .haddrOfs (haddrOfs),
    .hsize    (hsize),
    .predEnd  (predEnd),
    .lastBeat (lastBeat)
  );

  // R2
  accept_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (predEnd || lastBeat) |-> (hready && htrans[1]));

  // R9
  incr_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hburst == BU_INCR) |-> !lastBeat);
endmodule

// File: tb/sim_burstEndPredictor.sv
module sim_burstEndPredictor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] htrans = 2'b00;
  logic [2:0] hburst = 3'b001;
  logic       hready = 1'b1;
  logic [2:0] hsize = 3'd2;
  logic [9:0] haddrOfs = '0;
  logic [2:0] cfgLimit = '0;
  logic       predEnd, lastBeat;
  int checks = 0;
  int errors = 0;

  localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, NSEQ = 2'b10, SEQ = 2'b11;

  burstEndPredictor u0 (
    .clk(clk), .rst_n(rst_n), .htrans(htrans), .hburst(hburst), .hready(hready),
    .hsize(hsize), .haddrOfs(haddrOfs), .cfgLimit(cfgLimit),
    .predEnd(predEnd), .lastBeat(lastBeat)
  );

  always #10 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] t, input logic [2:0] b, input logic r,
                       input int a, input logic [2:0] s,
                       input logic expP, input logic expL, input string req);
    @(negedge clk);
    htrans = t; hburst = b; hready = r; haddrOfs = 10'(a); hsize = s;
    #5;
    check(predEnd, expP, {req, " predEnd"});
    check(lastBeat, expL, {req, " lastBeat"});
  endtask

  function automatic int limitOf(input int c);
    return (c == 1) ? 1 : (1 << c);
  endfunction

  // INCR stream with wait and busy cycles; expectations from beat position or address
  task automatic runIncr(input int cfg, input int size, input int start, input int n,
                         input string req);
    int addr = start;
    int bytes = 1 << size;
    int k = 0;
    cfgLimit = 3'(cfg);
    for (int i = 0; i < n; i++) begin
      logic expP;
      if (i % 7 == 3) drive(SEQ, 3'b001, 1'b0, addr, 3'(size), 1'b0, 1'b0, "R2 wait");
      if (i % 11 == 5) drive(BUSY, 3'b001, 1'b1, addr, 3'(size), 1'b0, 1'b0, "R5 busy");
      k++;
      if (cfg != 0) expP = (k % limitOf(cfg)) == 0;
      else          expP = ((addr % 1024) + bytes) >= 1024;
      drive((i == 0) ? NSEQ : SEQ, 3'b001, 1'b1, addr, 3'(size), expP, 1'b0,
            {req, " R9 R10"});
      addr += bytes;
    end
    drive(IDLE, 3'b001, 1'b1, 0, 3'(size), 1'b0, 1'b0, "R6 idle");
  endtask

  task automatic runFixed(input int b);
    int len = (b == 0) ? 1 : (1 << ((b >> 1) + 1));
    cfgLimit = 3'd1;
    for (int k = 1; k <= len; k++) begin
      if (k == 2) drive(SEQ, 3'(b), 1'b0, 4 * k, 3'd2, 1'b0, 1'b0, "R8 wait");
      drive((k == 1) ? NSEQ : SEQ, 3'(b), 1'b1, 4 * k, 3'd2, 1'b0, (k == len), "R8");
    end
    drive(IDLE, 3'(b), 1'b1, 0, 3'd2, 1'b0, 1'b0, "R8 idle");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cfgLimit = 3'd3;
    #5;
    check(predEnd, 1'b0, "R1 reset predEnd");
    check(lastBeat, 1'b0, "R1 reset lastBeat");
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: SEQ beats straight after reset, limit 8
    for (int k = 1; k <= 10; k++)
      drive(SEQ, 3'b001, 1'b1, 4 * k, 3'd2, (k == 8), 1'b0, "R1");
    drive(IDLE, 3'b001, 1'b1, 0, 3'd2, 1'b0, 1'b0, "R1 idle");

    // R3: every limit setting
    for (int c = 1; c <= 7; c++) runIncr(c, 2, 0, 300, "R3");

    // R7: unlimited, several sizes and start offsets
    runIncr(0, 2, 'h3C0, 300, "R7");
    runIncr(0, 3, 'h380, 200, "R7");
    runIncr(0, 0, 'h3F8, 20, "R7");

    // R8: defined-length bursts with limit 1 selected
    for (int b = 0; b <= 7; b++) if (b != 1) runFixed(b);

    // R4: NONSEQ restarts count (limit 8)
    cfgLimit = 3'd3;
    for (int k = 1; k <= 5; k++)
      drive((k == 1) ? NSEQ : SEQ, 3'b001, 1'b1, 4 * k, 3'd2, 1'b0, 1'b0, "R4 first");
    for (int k = 1; k <= 9; k++)
      drive((k == 1) ? NSEQ : SEQ, 3'b001, 1'b1, 4 * k, 3'd2, (k == 8), 1'b0, "R4");

    // R6: IDLE clears, SEQ after it counts from 1
    for (int k = 1; k <= 5; k++)
      drive((k == 1) ? NSEQ : SEQ, 3'b001, 1'b1, 4 * k, 3'd2, 1'b0, 1'b0, "R6 pre");
    drive(IDLE, 3'b001, 1'b1, 0, 3'd2, 1'b0, 1'b0, "R6 idle");
    for (int k = 1; k <= 9; k++)
      drive(SEQ, 3'b001, 1'b1, 4 * k, 3'd2, (k == 8), 1'b0, "R6");

    // R5: busy run, limit 4
    cfgLimit = 3'd2;
    drive(NSEQ, 3'b001, 1'b1, 0, 3'd2, 1'b0, 1'b0, "R5");
    drive(SEQ, 3'b001, 1'b1, 4, 3'd2, 1'b0, 1'b0, "R5");
    for (int j = 0; j < 3; j++) drive(BUSY, 3'b001, 1'b1, 8, 3'd2, 1'b0, 1'b0, "R5 busy");
    drive(SEQ, 3'b001, 1'b1, 8, 3'd2, 1'b0, 1'b0, "R5");
    drive(SEQ, 3'b001, 1'b1, 12, 3'd2, 1'b1, 1'b0, "R5");
    drive(IDLE, 3'b001, 1'b1, 0, 3'd2, 1'b0, 1'b0, "R5 idle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule